// File: doc/BRIEF.md
# Multi-Context Folding Logic Element

This block is one reconfigurable logic cell that keeps several truth tables in a small local context store and swaps the active one while it runs. The same four-input lookup table can therefore compute a different Boolean function in different cycles, a technique known as temporal folding. Each context also carries a bypass bit that picks the output form:

- **Bypass set:** the output is the combinational table value.
- **Bypass clear:** the output is an output register that captures the table value.

A sequencer holds the active context pointer and an evaluation counter. The 2-bit `mode` input sets the folding level p:

- `2'b00` gives level 1 (the context advances after every evaluation).
- `2'b01` gives level 2.
- `2'b10` gives level 4.
- `2'b11` turns folding off, and the pointer never moves.

The `last_ctx` input marks the final context of the folding schedule. After that context has seen its p evaluations, the pointer returns to context 0. One cycle later, `fold_done` goes high for one cycle.

The data side is a single-beat stream with no back-pressure. The `run_en` input acts as the valid strobe: every cycle in which `run_en` is high and `restart` is low is one evaluation of `lut_in`, and the block always accepts it. There is no ready signal, so a producer never stalls. Configuration writes land only while `run_en` is low. The `restart` input is a synchronous control pin that returns the schedule to its start.

Top module: `mctx_fold_le`

## Requirements
- R1: After reset, `le_out` and `fold_done` are 0, the pointer and counter are 0, and every truth table and bypass bit reads as 0. An element that is run before any configuration therefore outputs 0 for every input.
- R2: When the active context has its bypass bit set, `le_out` equals bit `lut_in` of that context's 16-bit table in the same cycle. Bit index = the value of `lut_in[3:0]`.
- R3: When the active context has its bypass bit clear, `le_out` shows the output register. The register loads the table value at the clock edge that ends an evaluation under such a context, and otherwise holds.
- R4: With mode `2'b00`, `2'b01` or `2'b10`, the pointer moves to the next context after 1, 2 or 4 evaluations under the current one.
- R5: With mode `2'b11`, the active context never changes. Evaluations still update the output register.
- R6: When the pointer equals `last_ctx` and its p-th evaluation completes, the pointer returns to 0 and `fold_done` is 1 for exactly the following cycle. At all other times it is 0.
- R7: While `run_en` is low, the pointer, the counter and the output register hold their values.
- R8: A configuration write (`cfg_we` high) stores `cfg_table` and `cfg_bypass` into context `cfg_addr` at the clock edge, but only when `run_en` is low. A write presented while `run_en` is high is ignored.
- R9: `restart` high sets the pointer and counter to 0 at the next edge, performs no evaluation in that cycle, and clears `fold_done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Evaluation strobe; high means one evaluation this cycle |
| restart | input | 1 | Synchronous return of pointer and counter to zero |
| mode | input | 2 | Folding level: 00 = 1, 01 = 2, 10 = 4, 11 = off |
| last_ctx | input | 4 | Final context of the folding schedule |
| lut_in | input | 4 | Lookup-table select inputs |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 4 | Context written |
| cfg_table | input | 16 | Truth table written |
| cfg_bypass | input | 1 | Bypass bit written |
| le_out | output | 1 | Element output |
| fold_done | output | 1 | One-cycle pulse after a complete folding pass |

## Verification
The bench builds the element with its defaults of 16 contexts and four inputs. The scoreboard therefore sees the full 4-bit context address and 16-bit table width. It programs four contexts: two with bypass set and two with bypass clear. This lets a 4-context schedule mix combinational and registered outputs. The bench then steps the schedule through levels 1, 2 and 4, through folding off, and through a shortened two-context schedule. The scoreboard follows the pointer only through output values and `fold_done`, so a wrong advance count, a wrong wrap point or a late pulse each shows up as a mismatch.

// File: rtl/mctx_pkg.sv
package mctx_pkg;
  typedef enum logic [1:0] {
    FOLD_L1  = 2'b00,
    FOLD_L2  = 2'b01,
    FOLD_L4  = 2'b10,
    FOLD_OFF = 2'b11
  } fold_mode_e;

  localparam int CNT_W = 2;

  // index of the final evaluation under one context for a folding level
  function automatic logic [CNT_W-1:0] final_count(fold_mode_e m);
    case (m)
      FOLD_L2: final_count = 2'd1;
      FOLD_L4: final_count = 2'd3;
      default: final_count = 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/mctx_ctx_store.sv
module mctx_ctx_store #(
  parameter int NCTX = 16,
  parameter int NIN  = 4,
  localparam int CTXW = $clog2(NCTX),
  localparam int TW   = 1 << NIN
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_en,
  input  logic            we,
  input  logic [CTXW-1:0] waddr,
  input  logic [TW-1:0]   wtable,
  input  logic            wbyp,
  input  logic [CTXW-1:0] raddr,
  output logic [TW-1:0]   rtable,
  output logic            rbyp
);
  logic [NCTX-1:0][TW-1:0] tables;
  logic [NCTX-1:0]         byps;

  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tables[c] <= '0;
        byps[c]   <= 1'b0;
      end else if (we && !run_en && (waddr == CTXW'(c))) begin
        tables[c] <= wtable;
        byps[c]   <= wbyp;
      end
    end
  end

  assign rtable = tables[raddr];
  assign rbyp   = byps[raddr];

  // R8: the store is frozen while the element is running
  p_cfg_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |=> ($stable(tables) && $stable(byps)));
endmodule

// File: rtl/mctx_lut_cell.sv
module mctx_lut_cell #(
  parameter int NIN = 4,
  localparam int TW = 1 << NIN
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [TW-1:0]  table_bits,
  input  logic           bypass,
  input  logic [NIN-1:0] sel,
  input  logic           eval_en,
  output logic           y
);
  logic lut_val;
  logic q;
  logic load;

  assign lut_val = table_bits[sel];
  assign load    = eval_en && !bypass;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= 1'b0;
    else if (load) q <= lut_val;
  end

  assign y = bypass ? lut_val : q;

  // R3: register holds whenever no registered evaluation completes
  p_flop_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));
  // R3: a registered evaluation leaves its table value in the register
  p_flop_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q == $past(lut_val)));
endmodule

// File: rtl/mctx_seq.sv
module mctx_seq
  import mctx_pkg::*;
#(
  parameter int NCTX = 16,
  localparam int CTXW = $clog2(NCTX)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_en,
  input  logic            restart,
  input  logic [1:0]      mode,
  input  logic [CTXW-1:0] last_ctx,
  output logic [CTXW-1:0] ptr,
  output logic            fold_done
);
  localparam logic [CTXW-1:0]  PTR_ONE = 1;
  localparam logic [CNT_W-1:0] CNT_ONE = 1;

  fold_mode_e      mode_e;
  logic [CNT_W-1:0] cnt;
  logic            eval;
  logic            last_eval;
  logic            wrap;

  assign mode_e    = fold_mode_e'(mode);
  assign eval      = run_en && !restart && (mode_e != FOLD_OFF);
  assign last_eval = (cnt == final_count(mode_e));
  assign wrap      = eval && last_eval && (ptr == last_ctx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr       <= '0;
      cnt       <= '0;
      fold_done <= 1'b0;
    end else if (restart) begin
      ptr       <= '0;
      cnt       <= '0;
      fold_done <= 1'b0;
    end else begin
      fold_done <= wrap;
      if (eval) begin
        if (last_eval) begin
          cnt <= '0;
          ptr <= wrap ? '0 : ptr + PTR_ONE;
        end else begin
          cnt <= cnt + CNT_ONE;
        end
      end
    end
  end

  // R7: schedule state holds while idle
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !restart) |=> ($stable(ptr) && $stable(cnt)));
  // R9: restart returns the schedule to its start
  p_restart_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (ptr == '0 && cnt == '0 && !fold_done));
  // R5: no folding keeps the context fixed
  p_nofold_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_e == FOLD_OFF) |=> $stable(ptr));
  // R6: the pulse only follows a return to context 0
  p_done_at_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fold_done |-> (ptr == '0 && cnt == '0));
  // R4: the pointer only moves on a counter wrap
  p_ptr_on_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !(eval && last_eval)) |=> $stable(ptr));
endmodule

// File: rtl/mctx_fold_le.sv
module mctx_fold_le #(
  parameter int NCTX = 16,
  parameter int NIN  = 4,
  localparam int CTXW = $clog2(NCTX),
  localparam int TW   = 1 << NIN
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_en,
  input  logic            restart,
  input  logic [1:0]      mode,
  input  logic [CTXW-1:0] last_ctx,
  input  logic [NIN-1:0]  lut_in,
  input  logic            cfg_we,
  input  logic [CTXW-1:0] cfg_addr,
  input  logic [TW-1:0]   cfg_table,
  input  logic            cfg_bypass,
  output logic            le_out,
  output logic            fold_done
);
  logic [CTXW-1:0] ptr;
  logic [TW-1:0]   act_table;
  logic            act_byp;
  logic            eval_en;

  assign eval_en = run_en && !restart;

  mctx_seq #(.NCTX(NCTX)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .restart   (restart),
    .mode      (mode),
    .last_ctx  (last_ctx),
    .ptr       (ptr),
    .fold_done (fold_done)
  );

  mctx_ctx_store #(.NCTX(NCTX), .NIN(NIN)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_en (run_en),
    .we     (cfg_we),
    .waddr  (cfg_addr),
    .wtable (cfg_table),
    .wbyp   (cfg_bypass),
    .raddr  (ptr),
    .rtable (act_table),
    .rbyp   (act_byp)
  );

  mctx_lut_cell #(.NIN(NIN)) u_cell (
    .clk        (clk),
    .rst_n      (rst_n),
    .table_bits (act_table),
    .bypass     (act_byp),
    .sel        (lut_in),
    .eval_en    (eval_en),
    .y          (le_out)
  );

  // R1: outputs are quiet straight after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!le_out && !fold_done));
endmodule

// File: tb/mctx_fold_le_tb.sv
module mctx_fold_le_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0, restart = 1'b0, cfg_we = 1'b0, cfg_bypass = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [3:0]  last_ctx = 4'd3, lut_in = 4'd0, cfg_addr = 4'd0;
  logic [15:0] cfg_table = 16'h0;
  logic        le_out, fold_done;

  always #2 clk = ~clk;

  mctx_fold_le u_dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .restart(restart),
    .mode(mode), .last_ctx(last_ctx), .lut_in(lut_in), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_table(cfg_table), .cfg_bypass(cfg_bypass),
    .le_out(le_out), .fold_done(fold_done)
  );

  typedef struct { bit out; bit done; string tag; } exp_t;
  exp_t sb[$];
  int checks = 0, failures = 0;
  bit finished = 1'b0;

  // reference model state
  bit [15:0] m_tab [16];
  bit        m_byp [16];
  int        m_ptr = 0, m_cnt = 0;
  bit        m_q = 0, m_done = 0;

  function automatic int fold_p(input logic [1:0] md);
    case (md)
      2'b00: return 1;
      2'b01: return 2;
      2'b10: return 4;
      default: return 0;
    endcase
  endfunction

  task automatic cyc(input bit re, input bit rs, input logic [1:0] md,
                     input logic [3:0] lc, input logic [3:0] din,
                     input bit we, input logic [3:0] wa, input logic [15:0] wt,
                     input bit wb, input string tag);
    exp_t e;
    @(negedge clk);
    run_en = re; restart = rs; mode = md; last_ctx = lc; lut_in = din;
    cfg_we = we; cfg_addr = wa; cfg_table = wt; cfg_bypass = wb;
    e.out  = m_byp[m_ptr] ? m_tab[m_ptr][din] : m_q;
    e.done = m_done;
    e.tag  = tag;
    sb.push_back(e);
    // next-edge model update
    if (!re && we) begin
      m_tab[wa] = wt;
      m_byp[wa] = wb;
    end
    if (rs) begin
      m_ptr = 0; m_cnt = 0; m_done = 0;
    end else if (re) begin
      if (!m_byp[m_ptr]) m_q = m_tab[m_ptr][din];
      m_done = 0;
      if (fold_p(md) != 0) begin
        if (m_cnt == fold_p(md) - 1) begin
          m_cnt = 0;
          if (m_ptr == int'(lc)) begin
            m_ptr = 0; m_done = 1;
          end else m_ptr = (m_ptr + 1) % 16;
        end else m_cnt++;
      end
    end else m_done = 0;
  endtask

  task automatic run(input logic [1:0] md, input logic [3:0] lc,
                     input logic [3:0] din, input string tag);
    cyc(1, 0, md, lc, din, 0, 4'd0, 16'h0, 0, tag);
  endtask

  task automatic idle(input string tag);
    cyc(0, 0, mode, last_ctx, lut_in, 0, 4'd0, 16'h0, 0, tag);
  endtask

  task automatic cfg(input logic [3:0] wa, input logic [15:0] wt, input bit wb);
    cyc(0, 0, mode, last_ctx, 4'd0, 1, wa, wt, wb, "R8 write while idle");
  endtask

  // monitor: compares design outputs against the scoreboard
  initial begin
    forever begin
      exp_t e;
      @(negedge clk);
      #1;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        checks++;
        if (le_out !== e.out || fold_done !== e.done) begin
          failures++;
          $display("FAIL %s: le_out=%0b fold_done=%0b expected le_out=%0b fold_done=%0b",
                   e.tag, le_out, fold_done, e.out, e.done);
        end
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      finished = 1'b1;
      failures++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin m_tab[i] = '0; m_byp[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state and cleared tables
    idle("R1 reset idle");
    idle("R1 reset idle");
    for (int i = 0; i < 5; i++) run(2'b00, 4'd3, 4'(i * 5 + 1), "R1 tables cleared");
    cyc(0, 1, 2'b00, 4'd3, 4'd0, 0, 4'd0, 16'h0, 0, "R9 restart");

    // R8: program four contexts (ctx0 = in[0], ctx1 = in[3], ctx2 = AND, ctx3 = XOR)
    cfg(4'd0, 16'hAAAA, 1);
    cfg(4'd1, 16'hFF00, 1);
    cfg(4'd2, 16'h8000, 0);
    cfg(4'd3, 16'h6996, 0);

    // R2 R3 R4 R6: level-1 folding over four contexts
    for (int i = 0; i < 10; i++) run(2'b00, 4'd3, 4'((i * 7 + 3) % 16), "R2 R3 R4 R6 level-1");
    // R7: pause
    for (int i = 0; i < 3; i++) cyc(0, 0, 2'b00, 4'd3, 4'(i * 9), 0, 4'd0, 16'h0, 0, "R7 pause");
    // R4 R6: level-2
    for (int i = 0; i < 10; i++) run(2'b01, 4'd3, 4'((i * 11 + 5) % 16), "R4 R6 level-2");
    // R8: write attempted while running is ignored
    cyc(1, 0, 2'b01, 4'd3, 4'd15, 1, 4'd0, 16'h0000, 0, "R8 write while running");
    for (int i = 0; i < 8; i++) run(2'b01, 4'd3, 4'((i * 3 + 1) % 16), "R8 ctx0 unchanged");
    // R9: restart mid-run, then level-4
    cyc(1, 1, 2'b10, 4'd3, 4'd15, 0, 4'd0, 16'h0, 0, "R9 restart mid-run");
    for (int i = 0; i < 18; i++) run(2'b10, 4'd3, 4'((i * 5 + 2) % 16), "R4 R6 level-4");
    // R5: no folding keeps context 0
    cyc(0, 1, 2'b11, 4'd3, 4'd0, 0, 4'd0, 16'h0, 0, "R9 restart idle");
    for (int i = 0; i < 6; i++) run(2'b11, 4'd3, 4'(i * 3), "R5 no folding");
    // R5: no folding from a registered context
    cyc(0, 1, 2'b00, 4'd3, 4'd0, 0, 4'd0, 16'h0, 0, "R9 restart idle");
    run(2'b00, 4'd3, 4'd1, "R4 step to ctx1");
    run(2'b00, 4'd3, 4'd8, "R4 step to ctx2");
    for (int i = 0; i < 5; i++) run(2'b11, 4'd3, 4'(15 - i * 4), "R5 no folding ctx2");
    // R6: shortened schedule with last_ctx = 1
    cyc(0, 1, 2'b00, 4'd1, 4'd0, 0, 4'd0, 16'h0, 0, "R9 restart idle");
    for (int i = 0; i < 7; i++) run(2'b00, 4'd1, 4'((i * 9 + 1) % 16), "R6 last_ctx 1");
    idle("R6 pulse clears");
    idle("R7 idle hold");

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule